// File: doc/BRIEF.md
# Two-Bank Shared Word Memory with Fetch/Data Arbitration

This block holds 2048 words of 16 bits in two independent single-ported banks and serves two requesters at once: a read-only fetch port (instruction and coefficient traffic) and a read/write data port. Each port has its own address bus and its own data bus. Any address is reachable from either port. The most significant address bit picks the bank. When the two ports touch different banks in a cycle, both accesses go through in that cycle with no wait.

If both ports reach the same bank in one cycle, the data port wins. A two-state controller handles this. In state `ARB_FREE` a same-bank collision drops `fetch_ready` for that cycle, latches the fetch address and takes the transition `FREE->WAIT`. In state `ARB_WAIT` the latched fetch address is served. If the data port is idle or uses the other bank, the controller raises `fetch_ready` and takes `WAIT->FREE`. If the data port hits the same bank again, it keeps priority and the controller takes `WAIT->WAIT`. Without a collision the controller stays in `ARB_FREE` (`FREE->FREE`).

Reads are synchronous. Each port's read data and a matching valid pulse appear in the cycle after its access is granted. Data-port writes commit at the clock edge that grants them.

Top module: `banked_dual_ram`

## Requirements
- R1: After reset, `fetch_ready` is 1 while the data port is idle, and `fetch_rvalid` and `data_rvalid` are 0.
- R2: A word written through the data port at any of the 2048 addresses is returned by a later data-port read of that address.
- R3: A fetch accepted in cycle t (`fetch_req` and `fetch_ready` both 1) gives `fetch_rvalid`=1 and the stored word on `fetch_rdata` in cycle t+1. A cycle with `fetch_ready`=0 gives `fetch_rvalid`=0 in the next cycle.
- R4: Address bit 10 selects the bank. If the two ports request addresses that differ in bit 10, `fetch_ready` stays 1 and both reads return their words in the next cycle.
- R5: If both ports request addresses with equal bit 10 while the controller is in `ARB_FREE`, `fetch_ready` is 0 in that cycle and the data access still completes in that cycle.
- R6: In the cycle after a collision, if the data port is idle or uses the other bank, `fetch_ready` is 1 and the held fetch completes, so the fetch waits exactly one cycle.
- R7: On a same-bank collision the data access happens first. A data write and a fetch to the same address in one cycle give the fetch the newly written word.
- R8: The data port is never stalled. Every data read yields `data_rvalid`=1 and its word one cycle later, including reads issued during a fetch wait.
- R9: A data write produces no `data_rvalid` pulse in the next cycle.
- R10: If the data port hits the held fetch's bank again during the wait cycle, the data port keeps priority and `fetch_ready` stays 0 for another cycle.
- R11: While a fetch is held, the address on `fetch_addr` is ignored. The fetch returns the word at the address latched when the collision occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch port read request; must be held while `fetch_ready` is 0 |
| fetch_addr | input | 11 | Fetch word address; bit 10 selects the bank |
| fetch_ready | output | 1 | Fetch accepted this cycle; 0 during a wait-state |
| fetch_rvalid | output | 1 | Fetch read data valid |
| fetch_rdata | output | 16 | Fetch read data |
| data_req | input | 1 | Data port request |
| data_we | input | 1 | Data port write enable (1 = write, 0 = read) |
| data_addr | input | 11 | Data word address; bit 10 selects the bank |
| data_wdata | input | 16 | Data port write word |
| data_rvalid | output | 1 | Data read data valid |
| data_rdata | output | 16 | Data read data |

## Verification
The two functions that meet in one cycle are the fetch access and the data access. The bench provokes same-bank collisions by pairing fetch addresses with data addresses that share bit 10. It samples `fetch_ready` before the clock edge and expects the data word at once and the fetch word one cycle later. The bench varies what the data port does in the wait cycle: nothing, the other bank, or the same bank again. It also collides a write with a fetch of the same address and checks that the fetch returns the new word, which confirms the data-first order.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [0:0] {
        ARB_FREE = 1'b0,
        ARB_WAIT = 1'b1
    } arb_state_e;

endpackage

// File: rtl/dpr_bank.sv
module dpr_bank #(
    parameter int OFF_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [OFF_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store[addr] <= wdata;
            end else begin
                rdata <= store[addr];
            end
        end
    end

endmodule

// File: rtl/dpr_arb_fsm.sv
module dpr_arb_fsm
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_req,
    input  logic [ADDR_W-1:0] data_addr,
    output logic              fetch_ready,
    output logic              fetch_go,
    output logic [ADDR_W-1:0] fetch_go_addr
);
    arb_state_e        state_q, state_d;
    logic [ADDR_W-1:0] held_q;
    logic [BANK_W-1:0] fbank, dbank, hbank;
    logic              clash_live, clash_held;

    assign fbank      = fetch_addr[ADDR_W-1 -: BANK_W];
    assign dbank      = data_addr[ADDR_W-1 -: BANK_W];
    assign hbank      = held_q[ADDR_W-1 -: BANK_W];
    assign clash_live = fetch_req && data_req && (fbank == dbank);
    assign clash_held = data_req && (hbank == dbank);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_FREE && clash_live) begin
                held_q <= fetch_addr;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_FREE: if (clash_live)  state_d = ARB_WAIT;
            ARB_WAIT: if (!clash_held) state_d = ARB_FREE;
        endcase
    end

    // outputs
    always_comb begin
        fetch_ready   = 1'b1;
        fetch_go      = 1'b0;
        fetch_go_addr = fetch_addr;
        unique case (state_q)
            ARB_FREE: begin
                fetch_ready = !clash_live;
                fetch_go    = fetch_req && !clash_live;
            end
            ARB_WAIT: begin
                fetch_go_addr = held_q;
                fetch_ready   = !clash_held;
                fetch_go      = !clash_held;
            end
        endcase
    end

endmodule

// File: rtl/dpr_route.sv
module dpr_route #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int BANK_W = 1,
    parameter int BANKS  = 2,
    parameter int OFF_W  = 10
) (
    input  logic                          data_req,
    input  logic                          data_we,
    input  logic [ADDR_W-1:0]             data_addr,
    input  logic [DATA_W-1:0]             data_wdata,
    input  logic                          fetch_go,
    input  logic [ADDR_W-1:0]             fetch_go_addr,
    output logic [BANKS-1:0]              b_en,
    output logic [BANKS-1:0]              b_we,
    output logic [BANKS-1:0][OFF_W-1:0]   b_addr,
    output logic [BANKS-1:0][DATA_W-1:0]  b_wdata
);
    logic [BANK_W-1:0] dbank, fbank;

    assign dbank = data_addr[ADDR_W-1 -: BANK_W];
    assign fbank = fetch_go_addr[ADDR_W-1 -: BANK_W];

    for (genvar g = 0; g < BANKS; g++) begin : g_lane
        logic d_hit, f_hit;
        assign d_hit      = data_req && (dbank == BANK_W'(g));
        assign f_hit      = fetch_go && (fbank == BANK_W'(g));
        assign b_en[g]    = d_hit || f_hit;
        assign b_we[g]    = d_hit && data_we;
        assign b_addr[g]  = d_hit ? data_addr[OFF_W-1:0] : fetch_go_addr[OFF_W-1:0];
        assign b_wdata[g] = data_wdata;
    end

endmodule

// File: rtl/dpr_return.sv
module dpr_return #(
    parameter int DATA_W = 16,
    parameter int BANK_W = 1,
    parameter int BANKS  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          data_rd,
    input  logic [BANK_W-1:0]             data_bank,
    input  logic                          fetch_go,
    input  logic [BANK_W-1:0]             fetch_bank,
    input  logic [BANKS-1:0][DATA_W-1:0]  b_rdata,
    output logic                          data_rvalid,
    output logic [DATA_W-1:0]             data_rdata,
    output logic                          fetch_rvalid,
    output logic [DATA_W-1:0]             fetch_rdata
);
    logic [BANK_W-1:0] dsel_q, fsel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_rvalid  <= 1'b0;
            fetch_rvalid <= 1'b0;
            dsel_q       <= '0;
            fsel_q       <= '0;
        end else begin
            data_rvalid  <= data_rd;
            fetch_rvalid <= fetch_go;
            if (data_rd)  dsel_q <= data_bank;
            if (fetch_go) fsel_q <= fetch_bank;
        end
    end

    assign data_rdata  = b_rdata[dsel_q];
    assign fetch_rdata = b_rdata[fsel_q];

endmodule

// File: rtl/banked_dual_ram.sv
module banked_dual_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              fetch_rvalid,
    output logic [DATA_W-1:0] fetch_rdata,
    input  logic              data_req,
    input  logic              data_we,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    output logic              data_rvalid,
    output logic [DATA_W-1:0] data_rdata
);
    localparam int BANKS = 1 << BANK_W;
    localparam int OFF_W = ADDR_W - BANK_W;

    logic                          fetch_go;
    logic [ADDR_W-1:0]             fetch_go_addr;
    logic [BANKS-1:0]              b_en, b_we;
    logic [BANKS-1:0][OFF_W-1:0]   b_addr;
    logic [BANKS-1:0][DATA_W-1:0]  b_wdata, b_rdata;

    dpr_arb_fsm #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_req     (fetch_req),
        .fetch_addr    (fetch_addr),
        .data_req      (data_req),
        .data_addr     (data_addr),
        .fetch_ready   (fetch_ready),
        .fetch_go      (fetch_go),
        .fetch_go_addr (fetch_go_addr)
    );

    dpr_route #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
        .BANKS(BANKS), .OFF_W(OFF_W)
    ) u_route (
        .data_req      (data_req),
        .data_we       (data_we),
        .data_addr     (data_addr),
        .data_wdata    (data_wdata),
        .fetch_go      (fetch_go),
        .fetch_go_addr (fetch_go_addr),
        .b_en          (b_en),
        .b_we          (b_we),
        .b_addr        (b_addr),
        .b_wdata       (b_wdata)
    );

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        dpr_bank #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .en    (b_en[g]),
            .we    (b_we[g]),
            .addr  (b_addr[g]),
            .wdata (b_wdata[g]),
            .rdata (b_rdata[g])
        );
    end

    dpr_return #(.DATA_W(DATA_W), .BANK_W(BANK_W), .BANKS(BANKS)) u_ret (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_rd      (data_req && !data_we),
        .data_bank    (data_addr[ADDR_W-1 -: BANK_W]),
        .fetch_go     (fetch_go),
        .fetch_bank   (fetch_go_addr[ADDR_W-1 -: BANK_W]),
        .b_rdata      (b_rdata),
        .data_rvalid  (data_rvalid),
        .data_rdata   (data_rdata),
        .fetch_rvalid (fetch_rvalid),
        .fetch_rdata  (fetch_rdata)
    );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int ADDR_W = 11,
    parameter int BANK_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_ready,
    input logic              fetch_rvalid,
    input logic              data_req,
    input logic              data_we,
    input logic [ADDR_W-1:0] data_addr,
    input logic              data_rvalid
);
    logic same_bank;
    assign same_bank = fetch_addr[ADDR_W-1 -: BANK_W] == data_addr[ADDR_W-1 -: BANK_W];

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!fetch_rvalid && !data_rvalid));

    p_fetch_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ready) |=> fetch_rvalid);

    p_stall_noval_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_ready |=> !fetch_rvalid);

    p_split_nowait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && data_req && !same_bank && $past(fetch_ready)) |-> fetch_ready);

    p_clash_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && data_req && same_bank && $past(fetch_ready)) |-> !fetch_ready);

    p_one_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_ready |=> (fetch_ready || data_req));

    p_data_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && !data_we) |=> data_rvalid);

    p_write_noval_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && data_we) |=> !data_rvalid);

endmodule

bind banked_dual_ram dpr_checker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_req    (fetch_req),
    .fetch_addr   (fetch_addr),
    .fetch_ready  (fetch_ready),
    .fetch_rvalid (fetch_rvalid),
    .data_req     (data_req),
    .data_we      (data_we),
    .data_addr    (data_addr),
    .data_rvalid  (data_rvalid)
);

// File: tb/tb_banked_dual_ram.sv
module tb_banked_dual_ram;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 2048;
    localparam int HALF       = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [10:0] fetch_addr = '0;
    logic        fetch_ready, fetch_rvalid;
    logic [15:0] fetch_rdata;
    logic        data_req = 1'b0, data_we = 1'b0;
    logic [10:0] data_addr = '0;
    logic [15:0] data_wdata = '0;
    logic        data_rvalid;
    logic [15:0] data_rdata;

    logic [15:0] shadow [WORDS];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_dual_ram dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .fetch_rvalid(fetch_rvalid), .fetch_rdata(fetch_rdata),
        .data_req(data_req), .data_we(data_we), .data_addr(data_addr),
        .data_wdata(data_wdata), .data_rvalid(data_rvalid), .data_rdata(data_rdata)
    );

    function automatic logic [15:0] pat(input int a, input int seed);
        return 16'((a * 40503 + seed * 977 + 16'h1234) & 16'hFFFF);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic fr, input int fa, input logic dr, input logic dw,
                         input int da, input logic [15:0] dd);
        fetch_req  = fr;
        fetch_addr = 11'(fa);
        data_req   = dr;
        data_we    = dw;
        data_addr  = 11'(da);
        data_wdata = dd;
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
        end
    end

    initial begin
        int ia, da, ob, nv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(fetch_ready == 1'b1, "R1 ready", int'(fetch_ready), 1);
        chk(fetch_rvalid == 1'b0, "R1 fetch_rvalid", int'(fetch_rvalid), 0);
        chk(data_rvalid == 1'b0, "R1 data_rvalid", int'(data_rvalid), 0);

        // R2/R9: fill every word through the data port
        for (int a = 0; a < WORDS; a++) begin
            shadow[a] = pat(a, 1);
            drive(0, 0, 1, 1, a, shadow[a]);
            step();
            chk(data_rvalid == 1'b0, "R9 write no valid", int'(data_rvalid), 0);
        end
        // R2: read back every word on the data port
        for (int a = 0; a < WORDS; a++) begin
            drive(0, 0, 1, 0, a, 16'h0);
            step();
            chk(data_rvalid && data_rdata == shadow[a], "R2 data readback",
                int'(data_rdata), int'(shadow[a]));
        end
        // R3: every word through the fetch port
        for (int a = 0; a < WORDS; a++) begin
            drive(1, a, 0, 0, 0, 16'h0);
            chk(fetch_ready == 1'b1, "R3 ready", int'(fetch_ready), 1);
            step();
            chk(fetch_rvalid && fetch_rdata == shadow[a], "R3 fetch read",
                int'(fetch_rdata), int'(shadow[a]));
        end

        // R4: different banks complete together
        for (int a = 0; a < HALF; a += 7) begin
            ia = (a % 2 == 0) ? a : a + HALF;
            da = ia ^ HALF;
            drive(1, ia, 1, 0, da, 16'h0);
            chk(fetch_ready == 1'b1, "R4 no wait", int'(fetch_ready), 1);
            step();
            chk(fetch_rvalid && fetch_rdata == shadow[ia], "R4 fetch word",
                int'(fetch_rdata), int'(shadow[ia]));
            chk(data_rvalid && data_rdata == shadow[da], "R4 data word",
                int'(data_rdata), int'(shadow[da]));
        end

        // R5/R6/R8: same-bank collisions, wait cycle free or other bank
        for (int k = 0; k < 64; k++) begin
            ia = (k * 97) % WORDS;
            da = (ia & HALF) | ((k * 13 + 5) % HALF);
            drive(1, ia, 1, 0, da, 16'h0);
            chk(fetch_ready == 1'b0, "R5 stall", int'(fetch_ready), 0);
            step();
            chk(data_rvalid && data_rdata == shadow[da], "R5 data first",
                int'(data_rdata), int'(shadow[da]));
            chk(fetch_rvalid == 1'b0, "R3 no fetch valid on stall", int'(fetch_rvalid), 0);
            ob = da ^ HALF;
            if (k % 2 == 1) drive(1, ia, 1, 0, ob, 16'h0);
            else            drive(1, ia, 0, 0, 0, 16'h0);
            chk(fetch_ready == 1'b1, "R6 one wait", int'(fetch_ready), 1);
            step();
            chk(fetch_rvalid && fetch_rdata == shadow[ia], "R6 held fetch",
                int'(fetch_rdata), int'(shadow[ia]));
            if (k % 2 == 1)
                chk(data_rvalid && data_rdata == shadow[ob], "R8 data in wait",
                    int'(data_rdata), int'(shadow[ob]));
        end

        // R7: write and fetch of the same address collide
        for (int k = 0; k < 16; k++) begin
            ia = (k * 131 + 3) % WORDS;
            nv = int'(pat(ia, 7 + k));
            drive(1, ia, 1, 1, ia, 16'(nv));
            chk(fetch_ready == 1'b0, "R5 stall on write", int'(fetch_ready), 0);
            step();
            shadow[ia] = 16'(nv);
            drive(1, ia, 0, 0, 0, 16'h0);
            step();
            chk(fetch_rvalid && fetch_rdata == shadow[ia], "R7 sees new word",
                int'(fetch_rdata), nv);
        end

        // R10: data hits the held bank again in the wait cycle
        for (int k = 0; k < 8; k++) begin
            ia = (k * 211 + 9) % WORDS;
            da = (ia & HALF) | ((k * 29) % HALF);
            drive(1, ia, 1, 0, da, 16'h0);
            step();
            ob = (ia & HALF) | ((k * 29 + 400) % HALF);
            drive(1, ia, 1, 0, ob, 16'h0);
            chk(fetch_ready == 1'b0, "R10 second wait", int'(fetch_ready), 0);
            step();
            chk(data_rvalid && data_rdata == shadow[ob], "R10 data still wins",
                int'(data_rdata), int'(shadow[ob]));
            drive(1, ia, 0, 0, 0, 16'h0);
            chk(fetch_ready == 1'b1, "R10 wait ends", int'(fetch_ready), 1);
            step();
            chk(fetch_rvalid && fetch_rdata == shadow[ia], "R10 held fetch",
                int'(fetch_rdata), int'(shadow[ia]));
        end

        // R11: live fetch address ignored during the wait
        for (int k = 0; k < 8; k++) begin
            ia = (k * 173 + 11) % WORDS;
            da = (ia & HALF) | ((k * 41 + 2) % HALF);
            drive(1, ia, 1, 0, da, 16'h0);
            step();
            drive(1, (ia + 517) % WORDS, 0, 0, 0, 16'h0);
            step();
            chk(fetch_rvalid && fetch_rdata == shadow[ia], "R11 latched address",
                int'(fetch_rdata), int'(shadow[ia]));
        end

        drive(0, 0, 0, 0, 0, 16'h0);
        step();
        chk(fetch_rvalid == 1'b0 && data_rvalid == 1'b0, "R3 idle no valid",
            int'({fetch_rvalid, data_rvalid}), 0);
        finished = 1'b1;
        summary();
    end

endmodule